// File: doc/BRIEF.md
# Any-Direction Line Rasterizer

The block draws a one-pixel-wide straight line between two screen points given as unsigned integers. A single start pulse loads both endpoints. The block then emits every pixel of the line on a valid/ready stream, one pixel per cycle while the consumer is ready. It marks the final pixel with a last flag.

Internally, a stepper works only in the shallow, increasing octant. There the major offset grows by one on every pixel, and the minor offset grows by one when an integer error term turns positive. Before stepping, the block records the direction of the line through three comparisons: whether x falls, whether y falls, and whether the y span exceeds the x span. Each emitted pixel is mapped back to the true direction relative to the start point. No multiplier or divider is involved. Address generation, colour and clipping belong to neighbouring blocks.

Top module: `line_raster`

## Requirements
- R1: After reset, pix_valid, pix_last and busy are all low.
- R2: The first pixel of a line equals the start point (ax, ay). The final pixel equals the end point (bx, by). pix_last is high on that pixel only, and pix_valid is low in the cycle after it is accepted.
- R3: The number of pixels emitted equals max(|bx-ax|, |by-ay|) + 1.
- R4: On consecutive pixels of one line, the major-axis coordinate changes by exactly one, and the other coordinate changes by at most one.
- R5: With M the larger span and m the smaller, an error term starts at 2m-M. After each pixel, if the error is greater than zero, the minor offset rises by one and the error loses 2M. In every case the error then gains 2m. The minor offset of each pixel follows this rule, so a tie (error exactly zero) does not step.
- R6: Lines in all eight directions are drawn correctly: rising and falling x, rising and falling y, shallow and steep. A steep line (|dy| > |dx|) uses y as its major axis.
- R7: A line whose endpoints coincide produces exactly one pixel, with pix_last high.
- R8: While pix_valid is high and pix_ready is low, pix_valid, pix_x, pix_y and pix_last hold their values.
- R9: busy is high from the cycle after start is taken until the last pixel is accepted. A start pulse while busy is high has no effect on the running line and does not queue a new one.
- R10: With pix_ready held high, the pixels of a line appear on consecutive cycles without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load endpoints and begin a line (taken only when idle) |
| ax | input | CW | Start point x |
| ay | input | CW | Start point y |
| bx | input | CW | End point x |
| by | input | CW | End point y |
| pix_ready | input | 1 | Consumer accepts the current pixel |
| busy | output | 1 | A line is being prepared or emitted |
| pix_valid | output | 1 | Pixel output is valid |
| pix_x | output | CW | Pixel x |
| pix_y | output | CW | Pixel y |
| pix_last | output | 1 | Current pixel is the end point |

## Verification
The bench walks lines through every octant. These include pure horizontal and vertical lines, exact diagonals, a tie-heavy 2:1 slope and a line spanning the full coordinate range at the far edge of the screen. A wrong direction fold would show as mirrored pixels or a line that misses its end point. A wrong tie rule or error start would shift the minor coordinate by one pixel. A zero-length line catches a stepper that runs one pixel too far or never raises the last flag. Periodic back-pressure checks that a stalled pixel is held rather than skipped. A start pulse injected mid-line, with different endpoints, checks that the running line is neither restarted nor followed by a stray second line.

// File: rtl/line_raster_pkg.sv
package line_raster_pkg;
  typedef struct packed {
    logic neg_x;
    logic neg_y;
    logic swap;
  } octant_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FOLD,
    ST_INIT,
    ST_RUN
  } lr_state_t;
endpackage

// File: rtl/lr_octant_fold.sv
module lr_octant_fold
  import line_raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] ax,
  input  logic [CW-1:0] ay,
  input  logic [CW-1:0] bx,
  input  logic [CW-1:0] by,
  output octant_t       oct,
  output logic [CW-1:0] major_len,
  output logic [CW-1:0] minor_len
);
  logic [CW-1:0] span_x, span_y;

  always_comb begin
    oct.neg_x = (bx < ax);
    oct.neg_y = (by < ay);
    span_x    = oct.neg_x ? (ax - bx) : (bx - ax);
    span_y    = oct.neg_y ? (ay - by) : (by - ay);
    oct.swap  = (span_y > span_x);
    major_len = oct.swap ? span_y : span_x;
    minor_len = oct.swap ? span_x : span_y;
  end
endmodule

// File: rtl/lr_stepper.sv
module lr_stepper #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic [CW-1:0] major_len,
  input  logic [CW-1:0] minor_len,
  output logic [CW-1:0] u,
  output logic [CW-1:0] v,
  output logic          at_end
);
  localparam int DW = CW + 2;

  logic signed [DW-1:0] err;
  logic signed [DW-1:0] two_min, two_maj, maj_ext;

  always_comb begin
    two_min = $signed({1'b0, minor_len, 1'b0});
    two_maj = $signed({1'b0, major_len, 1'b0});
    maj_ext = $signed({2'b00, major_len});
    at_end  = (u == major_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u   <= '0;
      v   <= '0;
      err <= '0;
    end else if (init) begin
      u   <= '0;
      v   <= '0;
      err <= two_min - maj_ext;
    end else if (adv) begin
      u <= u + 1'b1;
      if (err > 0) begin
        v   <= v + 1'b1;
        err <= err + two_min - two_maj;
      end else begin
        err <= err + two_min;
      end
    end
  end

  // R5
  minor_le_major_chk: assert property (@(posedge clk) disable iff (rst) v <= u);
endmodule

// File: rtl/lr_unfold.sv
module lr_unfold
  import line_raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] ax,
  input  logic [CW-1:0] ay,
  input  octant_t       oct,
  input  logic [CW-1:0] u,
  input  logic [CW-1:0] v,
  output logic [CW-1:0] px,
  output logic [CW-1:0] py
);
  logic [CW-1:0] off_x, off_y;

  always_comb begin
    off_x = oct.swap ? v : u;
    off_y = oct.swap ? u : v;
    px    = oct.neg_x ? (ax - off_x) : (ax + off_x);
    py    = oct.neg_y ? (ay - off_y) : (ay + off_y);
  end
endmodule

// File: rtl/line_raster.sv
module line_raster
  import line_raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] ax,
  input  logic [CW-1:0] ay,
  input  logic [CW-1:0] bx,
  input  logic [CW-1:0] by,
  input  logic          pix_ready,
  output logic          busy,
  output logic          pix_valid,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          pix_last
);
  lr_state_t     state;
  logic [CW-1:0] sx, sy, ex, ey;
  octant_t       oct_d, oct_q;
  logic [CW-1:0] maj_d, min_d, maj_q, min_q;
  logic [CW-1:0] u, v;
  logic          at_end, adv, init;

  lr_octant_fold #(.CW(CW)) u_fold (
    .ax(sx), .ay(sy), .bx(ex), .by(ey),
    .oct(oct_d), .major_len(maj_d), .minor_len(min_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sx    <= '0;
      sy    <= '0;
      ex    <= '0;
      ey    <= '0;
      oct_q <= '0;
      maj_q <= '0;
      min_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          sx    <= ax;
          sy    <= ay;
          ex    <= bx;
          ey    <= by;
          state <= ST_FOLD;
        end
        ST_FOLD: begin
          oct_q <= oct_d;
          maj_q <= maj_d;
          min_q <= min_d;
          state <= ST_INIT;
        end
        ST_INIT: state <= ST_RUN;
        ST_RUN:  if (pix_ready && at_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    init      = (state == ST_INIT);
    pix_valid = (state == ST_RUN);
    adv       = pix_valid && pix_ready && !at_end;
    pix_last  = pix_valid && at_end;
    busy      = (state != ST_IDLE);
  end

  lr_stepper #(.CW(CW)) u_step (
    .clk(clk), .rst(rst), .init(init), .adv(adv),
    .major_len(maj_q), .minor_len(min_q),
    .u(u), .v(v), .at_end(at_end)
  );

  lr_unfold #(.CW(CW)) u_unfold (
    .ax(sx), .ay(sy), .oct(oct_q), .u(u), .v(v),
    .px(pix_x), .py(pix_y)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_last));

  // R2
  last_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && pix_ready && pix_last |=> !pix_valid);

  // R4
  adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && pix_ready && !pix_last |=> pix_valid &&
      ((pix_x == $past(pix_x)) || (pix_x == $past(pix_x) + 1'b1) || (pix_x == $past(pix_x) - 1'b1)) &&
      ((pix_y == $past(pix_y)) || (pix_y == $past(pix_y) + 1'b1) || (pix_y == $past(pix_y) - 1'b1)));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst) pix_valid |-> busy);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) pix_valid |-> u <= maj_q);
endmodule

// File: tb/sim_line_raster.sv
module sim_line_raster;
  localparam int CW = 12;
  localparam time TCLK = 10ns;
  localparam int NV = 11;
  // entry: ax, ay, bx, by, expected pixel count
  localparam logic [63:0] VEC [0:NV-1] = '{
    {12'd10,   12'd10,   12'd20, 12'd14,   16'd11},
    {12'd10,   12'd10,   12'd14, 12'd20,   16'd11},
    {12'd20,   12'd10,   12'd10, 12'd14,   16'd11},
    {12'd10,   12'd20,   12'd20, 12'd14,   16'd11},
    {12'd20,   12'd20,   12'd10, 12'd10,   16'd11},
    {12'd50,   12'd50,   12'd47, 12'd40,   16'd11},
    {12'd100,  12'd5,    12'd100, 12'd9,   16'd5},
    {12'd5,    12'd7,    12'd12, 12'd7,    16'd8},
    {12'd4095, 12'd4095, 12'd0,  12'd4090, 16'd4096},
    {12'd30,   12'd30,   12'd30, 12'd30,   16'd1},
    {12'd0,    12'd0,    12'd4,  12'd2,    16'd5}
  };

  logic clk = 0, rst = 1, start = 0, pix_ready = 0;
  logic [CW-1:0] ax = 0, ay = 0, bx = 0, by = 0;
  logic busy, pix_valid, pix_last;
  logic [CW-1:0] pix_x, pix_y;
  int n_chk = 0, n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  line_raster #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .ax(ax), .ay(ay), .bx(bx), .by(by),
    .pix_ready(pix_ready), .busy(busy), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_last(pix_last)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_line(input int a_x, input int a_y, input int b_x, input int b_y,
                          input int expcnt, input bit stall, input bit inject);
    int adx, ady, big, sml, e, mv, k, cyc, first, lastc, bad, badlast, badadj, badstall, badbusy;
    int ex_x, ex_y, px_prev, py_prev, hx, hy;
    bit steep, done, held;
    adx = (b_x >= a_x) ? b_x - a_x : a_x - b_x;
    ady = (b_y >= a_y) ? b_y - a_y : a_y - b_y;
    steep = ady > adx;
    big = steep ? ady : adx;
    sml = steep ? adx : ady;
    e = 2*sml - big; mv = 0; k = 0; cyc = 0; first = -1; lastc = 0;
    bad = 0; badlast = 0; badadj = 0; badstall = 0; badbusy = 0;
    px_prev = 0; py_prev = 0; hx = 0; hy = 0; held = 0; done = 0;
    @(negedge clk);
    ax = a_x[CW-1:0]; ay = a_y[CW-1:0]; bx = b_x[CW-1:0]; by = b_y[CW-1:0];
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 20000) begin
      pix_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      if (inject && cyc == 4) begin
        start = 1; ax = 0; ay = 0; bx = 40; by = 0;
      end else begin
        start = 0;
      end
      if (held && !(pix_valid && pix_x == hx[CW-1:0] && pix_y == hy[CW-1:0])) badstall++;
      held = 0;
      if (inject && cyc >= 2 && !busy) badbusy++;
      if (pix_valid) begin
        if (first < 0) first = cyc;
        if (!pix_ready) begin
          held = 1; hx = pix_x; hy = pix_y;
        end else begin
          ex_x = (b_x >= a_x) ? a_x + (steep ? mv : k) : a_x - (steep ? mv : k);
          ex_y = (b_y >= a_y) ? a_y + (steep ? k : mv) : a_y - (steep ? k : mv);
          if (pix_x != ex_x[CW-1:0] || pix_y != ex_y[CW-1:0]) begin
            if (bad == 0)
              $display("FAIL R5/R6 pixel %0d: actual (%0d,%0d) expected (%0d,%0d)", k, pix_x, pix_y, ex_x, ex_y);
            bad++;
          end
          if (pix_last != (k == big)) badlast++;
          if (k > 0) begin
            if ((steep ? (int'(pix_y) - py_prev) : (int'(pix_x) - px_prev)) * ((steep ? (b_y >= a_y) : (b_x >= a_x)) ? 1 : -1) != 1) badadj++;
            if ((steep ? (int'(pix_x) - px_prev) : (int'(pix_y) - py_prev)) > 1 ||
                (steep ? (int'(pix_x) - px_prev) : (int'(pix_y) - py_prev)) < -1) badadj++;
          end
          px_prev = pix_x; py_prev = pix_y;
          if (e > 0) begin mv++; e -= 2*big; end
          e += 2*sml;
          k++;
          lastc = cyc;
          if (pix_last) done = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(done, "R3", "line finished", int'(done), 1);
    chk(k == expcnt, "R3", "pixel count", k, expcnt);
    n_chk++;
    if (bad != 0) begin n_fail++; $display("FAIL R5 R6 mismatching pixels: actual %0d expected 0", bad); end
    chk(badlast == 0, "R2", "last flag misplaced", badlast, 0);
    chk(badadj == 0, "R4", "non-adjacent steps", badadj, 0);
    if (stall) chk(badstall == 0, "R8", "stalled pixel changed", badstall, 0);
    else chk(lastc - first + 1 == expcnt, "R10", "cycles for line", lastc - first + 1, expcnt);
    if (expcnt == 1) chk(badlast == 0 && k == 1, "R7", "single pixel line", k, 1);
    if (inject) chk(badbusy == 0, "R9", "busy dropped mid-line", badbusy, 0);
    chk(!pix_valid && !busy, "R9", "idle after last pixel", int'(busy), 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(!pix_valid && !busy, "R9", "stray start launched a line", int'(pix_valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!pix_valid && !pix_last && !busy, "R1", "outputs during reset", int'(pix_valid | busy | pix_last), 0);
    rst = 0;
    @(negedge clk);
    chk(!pix_valid && !busy, "R1", "outputs after reset", int'(pix_valid | busy), 0);
    for (int i = 0; i < NV; i++) begin
      run_line(int'(VEC[i][63:52]), int'(VEC[i][51:40]), int'(VEC[i][39:28]),
               int'(VEC[i][27:16]), int'(VEC[i][15:0]), (i % 2) == 1, 1'b0);
    end
    // R9: start pulse mid-line with different endpoints
    run_line(10, 10, 20, 14, 11, 1'b0, 1'b1);
    // R7: coincident endpoints at the far corner, under back-pressure
    run_line(4095, 0, 4095, 0, 1, 1'b1, 1'b0);
    // R6: exact steep diagonal-adjacent falling line
    run_line(0, 4095, 1, 0, 4096, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule